// File: doc/BRIEF.md
# Opaque Stipple Colour Expander

This block turns one 32-bit stipple word, written toward a frame-buffer address, into a burst of byte-enabled memory write beats. Each bit of the stipple word stands for one pixel. A set bit paints the foreground colour and a clear bit paints the background colour, so both colours are always written (opaque expansion). A separate pixel-mask register chooses which pixels may be written at all, which lets software clip a partial glyph cell. Software supplies any sub-word shift already applied to both the stipple word and the pixel mask, and it bit-reverses byte-wise glyph data before writing it.

Two pixel depths are supported, picked per stipple word. At 8 bits per pixel one stipple word yields 8 beats of 4 pixels each, which covers 32 bytes. At 32 bits per pixel it yields 32 beats of one pixel each, which covers 128 bytes. The foreground, background and pixel-mask registers are loaded through a small register write port. The block takes a copy of them when it accepts a stipple word, and it takes no further word until the whole burst has been issued.

Top module: `stipple_expander`

## Requirements
- R1: After reset the foreground and background registers are zero, the pixel mask is all ones, `out_valid` is low and `st_ready` is high.
- R2: Stipple bit p maps to pixel p. Pixel 0 is the leftmost pixel: it sits at the lowest byte address of the burst and, at 8 bits per pixel, in byte lane 0 of the first beat.
- R3: An enabled pixel whose stipple bit is 1 receives the foreground colour, and one whose bit is 0 receives the background colour.
- R4: A pixel whose pixel-mask bit is 0 has all of its byte enables low in the beat that carries it. Any other pixel has its byte enables high.
- R5: With `depth_32` low (8 bits per pixel) a word gives exactly 8 beats. Beat k carries pixels 4k..4k+3, and byte lane j carries byte j of the selected colour register.
- R6: With `depth_32` high (32 bits per pixel) a word gives exactly 32 beats. Beat k carries pixel k as the full 32-bit colour, and its four byte enables are all equal.
- R7: The first beat goes out in the cycle after acceptance, at `st_addr` with its two low bits forced to zero. Each later beat goes out in the next cycle at an address 4 higher than the one before.
- R8: `st_ready` is low from acceptance until the last beat has been issued, and it is high again in the cycle after that beat. A word offered while `st_ready` is low is ignored.
- R9: The colour registers, the pixel mask and `depth_32` are captured when a word is accepted. A register write or a depth change made during a burst affects only later words.
- R10: Register select values on `cfg_sel` are 0 for foreground, 1 for background and 2 for pixel mask. A write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| depth_32 | input | 1 | Pixel depth of the offered word: 0 means 8 bits per pixel, 1 means 32 bits per pixel |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 foreground, 1 background, 2 pixel mask, 3 none |
| cfg_wdata | input | 32 | Register write data |
| st_valid | input | 1 | A stipple word is offered |
| st_ready | output | 1 | A stipple word can be accepted |
| st_addr | input | 32 | Byte address of the leftmost pixel of the offered word |
| st_mask | input | 32 | Stipple word, bit 0 for the leftmost pixel |
| out_valid | output | 1 | A write beat is presented |
| out_addr | output | 32 | Word-aligned byte address of the beat |
| out_data | output | 32 | Beat data |
| out_be | output | 4 | Byte enables of the beat, bit j for byte lane j |

## Verification
A wrong beat index shows at the ports in the same beat, as an address that is off by a multiple of 4 and as data or enables taken from the wrong stipple bits. A stuck busy state keeps `st_ready` low past the last expected beat, and the next compare one cycle later catches it. A register captured at the wrong time shows in the very first beat of the burst as the colour or enable pattern of the previous or the following configuration.

// File: rtl/stipple_pkg.sv
`timescale 1ns/1ps
// Shared types for the stipple colour expander.
package stipple_pkg;
    // Register select codes on the configuration port.
    typedef enum logic [1:0] {
        SEL_FG    = 2'd0,
        SEL_BG    = 2'd1,
        SEL_PMASK = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/stipple_cfg_regs.sv
`timescale 1ns/1ps
// Colour and pixel-mask registers.
// Assumes: one register write per cycle; select 3 writes nothing.
module stipple_cfg_regs #(
    parameter int DATA_W = 32,
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] fg,
    output logic [DATA_W-1:0] bg,
    output logic [MASK_W-1:0] pmask
);
    import stipple_pkg::*;

    // Load the addressed register, reset colours to zero and the mask to ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fg    <= '0;
            bg    <= '0;
            pmask <= '1;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_FG:    fg    <= wdata;
                SEL_BG:    bg    <= wdata;
                SEL_PMASK: pmask <= MASK_W'(wdata);
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/stipple_seq.sv
`timescale 1ns/1ps
// Burst sequencer: accepts a stipple word when idle, captures the word,
// the colours, the pixel mask and the depth, then steps a beat index
// once per cycle until the last beat of that depth.
// Assumes: MASK_W is a power of two and a multiple of DATA_W/8.
module stipple_seq #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int IDX_W = $clog2(MASK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [MASK_W-1:0] req_mask,
    input  logic              req_depth,
    input  logic [DATA_W-1:0] cur_fg,
    input  logic [DATA_W-1:0] cur_bg,
    input  logic [MASK_W-1:0] cur_pmask,
    output logic              busy,
    output logic [IDX_W-1:0]  beat_idx,
    output logic              run_depth,
    output logic [ADDR_W-1:0] run_addr,
    output logic [MASK_W-1:0] run_mask,
    output logic [MASK_W-1:0] run_pmask,
    output logic [DATA_W-1:0] run_fg,
    output logic [DATA_W-1:0] run_bg
);
    localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(MASK_W - 1);
    localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(MASK_W / LANES - 1);

    logic             accept;
    logic [IDX_W-1:0] last_idx;

    // Idle means ready; acceptance and the last beat index follow the depth.
    always_comb begin
        req_ready = !busy;
        accept    = req_valid && !busy;
        last_idx  = run_depth ? LAST_WIDE : LAST_NARROW;
    end

    // Run state: start on acceptance, advance per beat, stop after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            beat_idx <= '0;
        end else if (accept) begin
            busy     <= 1'b1;
            beat_idx <= '0;
        end else if (busy) begin
            if (beat_idx == last_idx) begin
                busy     <= 1'b0;
                beat_idx <= '0;
            end else begin
                beat_idx <= beat_idx + 1'b1;
            end
        end
    end

    // Capture of the word and the configuration at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_depth <= 1'b0;
            run_addr  <= '0;
            run_mask  <= '0;
            run_pmask <= '1;
            run_fg    <= '0;
            run_bg    <= '0;
        end else if (accept) begin
            run_depth <= req_depth;
            run_addr  <= req_addr;
            run_mask  <= req_mask;
            run_pmask <= cur_pmask;
            run_fg    <= cur_fg;
            run_bg    <= cur_bg;
        end
    end
endmodule

// File: rtl/stipple_lanes.sv
`timescale 1ns/1ps
// Per-byte-lane colour selection for one beat.
// At the narrow depth lane j shows pixel idx*LANES+j using byte j of the
// chosen colour; at the wide depth every lane shows pixel idx.
module stipple_lanes #(
    parameter int MASK_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int IDX_W  = $clog2(MASK_W),
    localparam int LANE_SH = $clog2(LANES)
) (
    input  logic              wide,
    input  logic [IDX_W-1:0]  idx,
    input  logic [MASK_W-1:0] mask,
    input  logic [MASK_W-1:0] pmask,
    input  logic [DATA_W-1:0] fg,
    input  logic [DATA_W-1:0] bg,
    output logic [DATA_W-1:0] data,
    output logic [LANES-1:0]  be
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [IDX_W-1:0] pix;
        // Pixel number served by this lane, then its colour byte and enable.
        always_comb begin
            pix = wide ? idx : ((idx << LANE_SH) | IDX_W'(j));
            data[8*j +: 8] = mask[pix] ? fg[8*j +: 8] : bg[8*j +: 8];
            be[j]          = pmask[pix];
        end
    end
endmodule

// File: rtl/stipple_expander.sv
`timescale 1ns/1ps
// Opaque stipple colour expander, top level.
// One accepted stipple word becomes MASK_W/LANES beats (narrow depth) or
// MASK_W beats (wide depth), one per cycle, at word-aligned addresses
// stepping by LANES bytes. Assumes the consumer takes a beat every cycle.
module stipple_expander #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              depth_32,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [MASK_W-1:0] st_mask,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [LANES-1:0]  out_be
);
    localparam int IDX_W   = $clog2(MASK_W);
    localparam int LANE_SH = $clog2(LANES);
    localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'(LANES - 1);

    logic [DATA_W-1:0] fg, bg, run_fg, run_bg;
    logic [MASK_W-1:0] pmask, run_pmask, run_mask;
    logic [ADDR_W-1:0] run_addr;
    logic [IDX_W-1:0]  beat_idx;
    logic              busy, run_depth;

    stipple_cfg_regs #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .fg(fg), .bg(bg), .pmask(pmask)
    );

    stipple_seq #(.ADDR_W(ADDR_W), .MASK_W(MASK_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(st_valid), .req_ready(st_ready),
        .req_addr(st_addr), .req_mask(st_mask), .req_depth(depth_32),
        .cur_fg(fg), .cur_bg(bg), .cur_pmask(pmask),
        .busy(busy), .beat_idx(beat_idx), .run_depth(run_depth),
        .run_addr(run_addr), .run_mask(run_mask), .run_pmask(run_pmask),
        .run_fg(run_fg), .run_bg(run_bg)
    );

    stipple_lanes #(.MASK_W(MASK_W), .DATA_W(DATA_W)) u_lanes (
        .wide(run_depth), .idx(beat_idx), .mask(run_mask), .pmask(run_pmask),
        .fg(run_fg), .bg(run_bg), .data(out_data), .be(out_be)
    );

    // Beat address: aligned start plus LANES bytes per beat.
    always_comb begin
        out_valid = busy;
        out_addr  = (run_addr & ALIGN)
                  + ({{(ADDR_W-IDX_W){1'b0}}, beat_idx} << LANE_SH);
    end
endmodule

// File: rtl/stipple_expander_checker.sv
`timescale 1ns/1ps
// Property checker for the stipple expander, bound to the top module.
module stipple_expander_checker #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic              st_ready,
    input logic [ADDR_W-1:0] st_addr,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic [3:0]        out_be,
    input logic              run_depth
);
    localparam int CW = $clog2(MASK_W) + 2;
    logic [CW-1:0] beat_cnt;

    // Count beats of the current burst; clear between bursts.
    always_ff @(posedge clk) begin
        if (!rst_n)         beat_cnt <= '0;
        else if (out_valid) beat_cnt <= beat_cnt + 1'b1;
        else                beat_cnt <= '0;
    end

    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !st_ready);

    assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> st_ready);

    assert_first_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready) |=> (out_valid
            && out_addr == ($past(st_addr) & ~ADDR_W'(3))));

    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> out_addr == $past(out_addr) + ADDR_W'(4));

    assert_word_enables_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && run_depth) |-> (out_be == 4'h0 || out_be == 4'hF));

    assert_beat_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(out_valid)) |->
            beat_cnt == (run_depth ? CW'(MASK_W) : CW'(MASK_W / 4)));
endmodule

bind stipple_expander stipple_expander_checker #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .out_valid(out_valid), .out_addr(out_addr),
    .out_be(out_be), .run_depth(run_depth)
);

// File: tb/stipple_expander_bench.sv
`timescale 1ns/1ps
// Bench: behavioural queue model of expected beats, compared every cycle.
module stipple_expander_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        depth_32 = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_addr = '0;
    logic [31:0] st_mask = '0;
    logic        out_valid;
    logic [31:0] out_addr, out_data;
    logic [3:0]  out_be;

    stipple_expander u_stipple_expander (
        .clk(clk), .rst_n(rst_n), .depth_32(depth_32), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .st_valid(st_valid),
        .st_ready(st_ready), .st_addr(st_addr), .st_mask(st_mask),
        .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data),
        .out_be(out_be)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    logic [31:0] m_fg = '0, m_bg = '0, m_pm = '1;
    logic [31:0] q_addr[$], q_data[$];
    logic [3:0]  q_be[$];
    string       q_tag[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Expected beats of one accepted word, from the requirements.
    task automatic push_run(input logic [31:0] addr, input logic [31:0] mask,
                            input bit wide, input string tag);
        int nb = wide ? 32 : 8;
        for (int k = 0; k < nb; k++) begin
            logic [31:0] d = '0;
            logic [3:0]  b = '0;
            if (wide) begin
                d = mask[k] ? m_fg : m_bg;
                b = m_pm[k] ? 4'hF : 4'h0;
            end else begin
                for (int j = 0; j < 4; j++) begin
                    d[8*j +: 8] = mask[4*k+j] ? m_fg[8*j +: 8] : m_bg[8*j +: 8];
                    b[j] = m_pm[4*k+j];
                end
            end
            q_addr.push_back({addr[31:2], 2'b00} + 32'(4*k));
            q_data.push_back(d);
            q_be.push_back(b);
            q_tag.push_back(tag);
        end
    endtask

    // Compare outputs against the model head.
    task automatic compare;
        bit exp_v = (q_addr.size() > 0);
        string t = exp_v ? q_tag[0] : cur_tag;
        chk(out_valid == exp_v, t, "out_valid", 32'(out_valid), 32'(exp_v));
        chk(st_ready == !exp_v, "R8", "st_ready", 32'(st_ready), 32'(!exp_v));
        if (exp_v) begin
            if (out_valid) begin
                chk(out_addr == q_addr[0], t, "out_addr", out_addr, q_addr[0]);
                chk(out_data == q_data[0], t, "out_data", out_data, q_data[0]);
                chk(out_be == q_be[0], t, "out_be", 32'(out_be), 32'(q_be[0]));
            end
            void'(q_addr.pop_front()); void'(q_data.pop_front());
            void'(q_be.pop_front());   void'(q_tag.pop_front());
        end
    endtask

    // One clock: model the coming edge, then compare after it.
    task automatic step;
        if (st_valid && st_ready) push_run(st_addr, st_mask, depth_32, cur_tag);
        if (cfg_we) begin
            case (cfg_sel)
                2'd0: m_fg = cfg_wdata;
                2'd1: m_bg = cfg_wdata;
                2'd2: m_pm = cfg_wdata;
                default: ;
            endcase
        end
        @(negedge clk);
        compare();
    endtask

    task automatic cfg(input logic [1:0] s, input logic [31:0] v);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic drain;
        while (q_addr.size() > 0 || !st_ready) step();
        step();
    endtask

    task automatic send(input logic [31:0] a, input logic [31:0] m,
                        input bit wide, input string tag);
        cur_tag = tag;
        st_addr = a; st_mask = m; depth_32 = wide; st_valid = 1'b1;
        step();
        st_valid = 1'b0;
        drain();
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset, then defaults give background zero, all enabled.
        cur_tag = "R1";
        step();
        send(32'h0000_0400, 32'hFFFF_0000, 1'b0, "R1");

        // R2 R3 R5: narrow depth, colour selection per bit, lane ordering.
        cfg(2'd0, 32'h5A5A_5A5A);
        cfg(2'd1, 32'h0303_0303);
        send(32'h0000_1000, 32'h0000_00F1, 1'b0, "R2");
        send(32'h0000_1020, 32'h8421_C3A5, 1'b0, "R3");
        cfg(2'd0, 32'hA1B2_C3D4);
        send(32'h0000_1040, 32'h1234_5678, 1'b0, "R5");

        // R4 R7: clipped glyph cell, unaligned start address.
        cfg(2'd2, 32'h0000_FFF0);
        send(32'h0000_2003, 32'hA5A5_3C3C, 1'b0, "R4");
        send(32'h0000_2042, 32'hFFFF_FFFF, 1'b0, "R7");

        // R6: wide depth, one pixel per beat.
        cfg(2'd0, 32'h00FF_8040);
        cfg(2'd1, 32'h1122_3344);
        cfg(2'd2, 32'hFFFF_00FF);
        send(32'h0001_0000, 32'h8000_0001, 1'b1, "R6");
        cfg(2'd2, 32'hFFFF_FFFF);
        send(32'h0001_0080, 32'h0F0F_F0F0, 1'b1, "R6");

        // R8: a second word held valid during a burst waits its turn.
        cur_tag = "R8";
        st_addr = 32'h0000_3000; st_mask = 32'h0000_FFFF; depth_32 = 1'b0;
        st_valid = 1'b1;
        step();
        st_addr = 32'h0000_3100; st_mask = 32'hDEAD_BEEF;
        while (!st_ready) step();
        step();
        st_valid = 1'b0;
        drain();

        // R9: register writes and depth change during a burst affect the next word.
        cur_tag = "R9";
        st_addr = 32'h0000_4000; st_mask = 32'h3333_CCCC; depth_32 = 1'b1;
        st_valid = 1'b1;
        step();
        st_valid = 1'b0;
        depth_32 = 1'b0;
        cfg(2'd0, 32'h7777_7777);
        cfg(2'd2, 32'hF0F0_F0F0);
        drain();
        send(32'h0000_4100, 32'h3333_CCCC, 1'b0, "R9");

        // R10: select 3 writes nothing; colours stay as modelled.
        cfg(2'd3, 32'h0000_0000);
        cfg(2'd2, 32'hFFFF_FFFF);
        send(32'h0000_5000, 32'h6969_9696, 1'b0, "R10");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule